// File: doc/BRIEF.md
# Self-Seeding PRBS Error Detector

This block compares a stream of received parallel words against the pseudo-random binary sequence it expects to see. It needs no knowledge of where the transmitter started. While it has no lock, it treats every received word as the state of its own sequence generator. It predicts the next word from that state and checks the prediction against what actually arrives. Once a programmable number of consecutive predictions come out clean, the block declares pattern match. From then on its generator runs only on its own state, so a corrupted word on the line can never pull the reference off the true sequence.

After match, every compared word produces an error mask. The block also keeps two saturating tallies of wrong bits, split by direction: bits expected high but received low, and bits expected low but received high. A separate link-lock input, driven by the receive front end, is the only thing besides reset that removes the match. A burst of errored words alone never does. Four sequence polynomials can be selected. The data width must be at least 31 bits, so that one word holds the full state of the longest polynomial.

Top module: `prbs_err_detector`

## Requirements
- R1: The pattern select picks the polynomial: 0 = x^7+x^6+1, 1 = x^15+x^14+1, 2 = x^23+x^18+1, 3 = x^31+x^28+1. Bit DATA_W-1 of a word is the earliest bit in time and bit 0 the latest. The expected word is the next DATA_W bits of the recurrence b[n] = b[n-tap] ^ b[n-order], continued from the bits of the previous word.
- R2: A valid word accepted while not matched reloads the reference with the received word. The first valid word after reset or after loss of link only seeds the reference and is not compared, so err_mask_vld stays low for it.
- R3: Each compared word raises err_mask_vld one cycle later, with err_mask equal to the received word XOR the expected word.
- R4: Match is declared one cycle after the match_run-th consecutive compared word with an all-zero mask; a match_run of 0 acts as 1. A compared word with a nonzero mask restarts the run while unmatched.
- R5: While matched, the reference advances from its own expected word and ignores the received data, so an errored word does not change the masks of the words after it.
- R6: While link_ok stays high, matched never falls, whatever the error content of the received words.
- R7: link_ok low clears matched on the next cycle, and words presented while it is low are ignored. The next valid word after the link returns only seeds the reference.
- R8: On each compared word while matched, cnt_hi2lo grows by the number of bits set in (mask AND expected) and cnt_lo2hi by the number set in (mask AND NOT expected). Neither counter changes while unmatched.
- R9: Both counters saturate at all-ones and stay there.
- R10: After reset, matched, err_mask_vld, err_mask and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | DATA_W | Received parallel word |
| rx_valid | input | 1 | rx_word holds a word this cycle |
| pat_sel | input | 2 | Polynomial select (R1 encoding) |
| link_ok | input | 1 | Link lock status from the receive front end |
| match_run | input | RUN_W | Consecutive clean words needed for match |
| matched | output | 1 | Pattern match declared |
| err_mask | output | DATA_W | Error bits of the last compared word |
| err_mask_vld | output | 1 | err_mask updated this cycle |
| cnt_hi2lo | output | CNT_W | Saturating count of expected-1/received-0 bits |
| cnt_lo2hi | output | CNT_W | Saturating count of expected-0/received-1 bits |

## Verification
The assertions check the cycle-level rules on every cycle. While the link holds, match never falls. Loss of link removes match and compare on the next cycle. Match rises only at the edge of a valid clean word. The counters stay frozen while unmatched and hold once saturated, and a word accepted while matched always yields a mask. Only the bench's scenarios can show that the masks and flip tallies have the right values for each polynomial and bit order, and that the run counter restarts after an error during hunting. They also show that a reference errored word leaves the following words clean once matched, and that the word after relink is used only as a seed.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    typedef enum logic [1:0] {
        PAT_P7  = 2'd0,
        PAT_P15 = 2'd1,
        PAT_P23 = 2'd2,
        PAT_P31 = 2'd3
    } pat_e;

    typedef enum logic [1:0] {
        SYNC_EMPTY = 2'd0,
        SYNC_HUNT  = 2'd1,
        SYNC_LOCK  = 2'd2
    } sync_e;

    localparam int NUM_PAT = 4;

    // degree of the generator polynomial
    function automatic int poly_order(pat_e p);
        case (p)
            PAT_P7:  return 7;
            PAT_P15: return 15;
            PAT_P23: return 23;
            default: return 31;
        endcase
    endfunction

    // middle tap of the generator polynomial
    function automatic int poly_tap(pat_e p);
        case (p)
            PAT_P7:  return 6;
            PAT_P15: return 14;
            PAT_P23: return 18;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              seed_rx,
    input  pat_e              pat_sel,
    input  logic [DATA_W-1:0] rx_word,
    output logic [DATA_W-1:0] exp_word
);

    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] cand [NUM_PAT];

    // one parallel next-word unit per polynomial; history index 0 is the latest bit
    for (genvar p = 0; p < NUM_PAT; p++) begin : g_poly
        localparam int ORD = poly_order(pat_e'(p));
        localparam int TAP = poly_tap(pat_e'(p));
        always_comb begin
            logic [DATA_W-1:0] h;
            logic              nb;
            h = ref_q;
            for (int k = 0; k < DATA_W; k++) begin
                nb = h[TAP-1] ^ h[ORD-1];
                h  = {h[DATA_W-2:0], nb};
            end
            cand[p] = h;
        end
    end

    assign exp_word = cand[pat_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
        end else if (step_en) begin
            ref_q <= seed_rx ? rx_word : exp_word;
        end
    end

endmodule

// File: rtl/prbs_sync_fsm.sv
module prbs_sync_fsm
    import prbs_chk_pkg::*;
#(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_ok,
    input  logic             word_vld,
    input  logic             word_clean,
    input  logic [RUN_W-1:0] match_run,
    output logic             matched,
    output logic             cmp_en,
    output logic             seed_rx
);

    sync_e            state_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W:0]   run_nxt;
    logic             run_done;

    assign run_nxt  = {1'b0, run_q} + {{RUN_W{1'b0}}, 1'b1};
    assign run_done = run_nxt >= {1'b0, match_run};

    assign matched = (state_q == SYNC_LOCK);
    assign cmp_en  = (state_q != SYNC_EMPTY);
    assign seed_rx = (state_q != SYNC_LOCK);

    always_ff @(posedge clk) begin
        if (rst || !link_ok) begin
            state_q <= SYNC_EMPTY;
            run_q   <= '0;
        end else if (word_vld) begin
            case (state_q)
                SYNC_EMPTY: begin
                    state_q <= SYNC_HUNT;
                    run_q   <= '0;
                end
                SYNC_HUNT: begin
                    if (!word_clean) begin
                        run_q <= '0;
                    end else if (run_done) begin
                        state_q <= SYNC_LOCK;
                        run_q   <= '0;
                    end else begin
                        run_q <= run_nxt[RUN_W-1:0];
                    end
                end
                SYNC_LOCK: state_q <= SYNC_LOCK;
                default:   state_q <= SYNC_EMPTY;
            endcase
        end
    end

    AST_MATCH_KEPT: assert property (@(posedge clk) disable iff (rst)
        matched && link_ok |=> matched); // R6

    AST_LINK_DROP: assert property (@(posedge clk) disable iff (rst)
        !link_ok |=> !matched && !cmp_en); // R7

    AST_LOCK_ON_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(matched) |-> $past(word_vld && word_clean && cmp_en)); // R4

endmodule

// File: rtl/prbs_flip_tally.sv
module prbs_flip_tally #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tally_en,
    input  logic [DATA_W-1:0] exp_word,
    input  logic [DATA_W-1:0] mask,
    output logic [CNT_W-1:0]  cnt_hi2lo,
    output logic [CNT_W-1:0]  cnt_lo2hi
);

    localparam int PCW = $clog2(DATA_W + 1);

    logic [PCW-1:0]   pc_h2l, pc_l2h;
    logic [CNT_W:0]   inc_h2l, inc_l2h;
    logic [CNT_W:0]   sum_h2l, sum_l2h;
    logic [CNT_W-1:0] h2l_q, l2h_q;

    always_comb begin
        pc_h2l = '0;
        pc_l2h = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pc_h2l = pc_h2l + {{(PCW-1){1'b0}}, mask[i] &  exp_word[i]};
            pc_l2h = pc_l2h + {{(PCW-1){1'b0}}, mask[i] & ~exp_word[i]};
        end
        inc_h2l = '0;
        inc_l2h = '0;
        inc_h2l[PCW-1:0] = pc_h2l;
        inc_l2h[PCW-1:0] = pc_l2h;
        sum_h2l = {1'b0, h2l_q} + inc_h2l;
        sum_l2h = {1'b0, l2h_q} + inc_l2h;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h2l_q <= '0;
            l2h_q <= '0;
        end else if (tally_en) begin
            h2l_q <= sum_h2l[CNT_W] ? '1 : sum_h2l[CNT_W-1:0];
            l2h_q <= sum_l2h[CNT_W] ? '1 : sum_l2h[CNT_W-1:0];
        end
    end

    assign cnt_hi2lo = h2l_q;
    assign cnt_lo2hi = l2h_q;

    AST_SAT_HOLD_H2L: assert property (@(posedge clk) disable iff (rst)
        &h2l_q |=> &h2l_q); // R9

    AST_SAT_HOLD_L2H: assert property (@(posedge clk) disable iff (rst)
        &l2h_q |=> &l2h_q); // R9

    AST_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (h2l_q >= $past(h2l_q)) && (l2h_q >= $past(l2h_q))); // R8

endmodule

// File: rtl/prbs_err_detector.sv
module prbs_err_detector
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RUN_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_valid,
    input  logic [1:0]        pat_sel,
    input  logic              link_ok,
    input  logic [RUN_W-1:0]  match_run,
    output logic              matched,
    output logic [DATA_W-1:0] err_mask,
    output logic              err_mask_vld,
    output logic [CNT_W-1:0]  cnt_hi2lo,
    output logic [CNT_W-1:0]  cnt_lo2hi
);

    logic              word_vld;
    logic              cmp_en;
    logic              seed_rx;
    logic              lock_s;
    logic [DATA_W-1:0] exp_word;
    logic [DATA_W-1:0] diff;
    logic              word_clean;
    logic              do_cmp;
    logic [DATA_W-1:0] mask_q;
    logic              mask_vld_q;

    assign word_vld   = rx_valid && link_ok;
    assign diff       = rx_word ^ exp_word;
    assign word_clean = (diff == '0);
    assign do_cmp     = word_vld && cmp_en;

    prbs_ref_gen #(.DATA_W(DATA_W)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .step_en  (word_vld),
        .seed_rx  (seed_rx),
        .pat_sel  (pat_e'(pat_sel)),
        .rx_word  (rx_word),
        .exp_word (exp_word)
    );

    prbs_sync_fsm #(.RUN_W(RUN_W)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .link_ok    (link_ok),
        .word_vld   (word_vld),
        .word_clean (word_clean),
        .match_run  (match_run),
        .matched    (lock_s),
        .cmp_en     (cmp_en),
        .seed_rx    (seed_rx)
    );

    prbs_flip_tally #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .tally_en  (do_cmp && lock_s),
        .exp_word  (exp_word),
        .mask      (diff),
        .cnt_hi2lo (cnt_hi2lo),
        .cnt_lo2hi (cnt_lo2hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '0;
            mask_vld_q <= 1'b0;
        end else begin
            mask_vld_q <= do_cmp;
            if (do_cmp) begin
                mask_q <= diff;
            end
        end
    end

    assign matched      = lock_s;
    assign err_mask     = mask_q;
    assign err_mask_vld = mask_vld_q;

    AST_LOCKED_COMPARES: assert property (@(posedge clk) disable iff (rst)
        matched && rx_valid && link_ok |=> err_mask_vld); // R3

    AST_NO_TALLY_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !matched |=> $stable(cnt_hi2lo) && $stable(cnt_lo2hi)); // R8

    AST_LOCK_MASK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(matched) |-> err_mask_vld && (err_mask == '0)); // R4

    AST_NOLINK_NO_MASK: assert property (@(posedge clk) disable iff (rst)
        !link_ok |=> !err_mask_vld); // R7

endmodule

// File: tb/tb_prbs_err_detector.sv
module tb_prbs_err_detector;

    localparam int W  = 32;
    localparam int RW = 8;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  rx_word;
    logic          rx_valid;
    logic [1:0]    pat_sel;
    logic          link_ok;
    logic [RW-1:0] match_run;
    logic          matched;
    logic [W-1:0]  err_mask;
    logic          err_mask_vld;
    logic [CW-1:0] cnt_hi2lo;
    logic [CW-1:0] cnt_lo2hi;

    prbs_err_detector #(.DATA_W(W), .RUN_W(RW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .rx_word(rx_word), .rx_valid(rx_valid),
        .pat_sel(pat_sel), .link_ok(link_ok), .match_run(match_run),
        .matched(matched), .err_mask(err_mask), .err_mask_vld(err_mask_vld),
        .cnt_hi2lo(cnt_hi2lo), .cnt_lo2hi(cnt_lo2hi)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int m_h2l = 0;
    int m_l2h = 0;
    logic [63:0] hist;

    // bit flips applied to consecutive words once matched
    localparam logic [W-1:0] FLIPS [8] = '{
        32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 32'h8000_0001,
        32'hFFFF_0000, 32'h0000_0000, 32'h0000_00F0, 32'h0000_0000
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // serial reference stream: newest bit enters hist[0]
    task automatic gen(input int sel, output logic [W-1:0] w);
        int n, a;
        logic b;
        case (sel)
            0: begin n = 7;  a = 6;  end
            1: begin n = 15; a = 14; end
            2: begin n = 23; a = 18; end
            default: begin n = 31; a = 28; end
        endcase
        for (int k = W - 1; k >= 0; k--) begin
            b = hist[a-1] ^ hist[n-1];
            hist = {hist[62:0], b};
            w[k] = b;
        end
    endtask

    task automatic step(input logic [W-1:0] w, input logic v);
        rx_word  = w;
        rx_valid = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tally(input logic [W-1:0] e, input logic [W-1:0] m);
        m_h2l += $countones(m & e);
        m_l2h += $countones(m & ~e);
        if (m_h2l > CMAX) m_h2l = CMAX;
        if (m_l2h > CMAX) m_l2h = CMAX;
    endtask

    task automatic chk_cnts(input string req);
        chk(req, "cnt_hi2lo", 64'(cnt_hi2lo), 64'(m_h2l));
        chk(req, "cnt_lo2hi", 64'(cnt_lo2hi), 64'(m_l2h));
    endtask

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] w;
        hist      = '1;
        rst       = 1'b1;
        rx_word   = '0;
        rx_valid  = 1'b0;
        pat_sel   = 2'd0;
        link_ok   = 1'b0;
        match_run = 8'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10", "matched", 64'(matched), 0);
        chk("R10", "err_mask_vld", 64'(err_mask_vld), 0);
        chk("R10", "err_mask", 64'(err_mask), 0);
        chk_cnts("R10");

        // hunting on x^7+x^6+1, run of 4
        link_ok = 1'b1;
        gen(0, w); step(w, 1'b1);
        chk("R2", "seed word not compared", 64'(err_mask_vld), 0);
        gen(0, w); step(w, 1'b1);
        chk("R3", "clean mask valid", 64'(err_mask_vld), 1);
        chk("R1", "clean mask", 64'(err_mask), 0);
        gen(0, w); step(w, 1'b1);
        gen(0, w); step(w ^ 32'h1, 1'b1);
        chk("R3", "errored mask", 64'(err_mask), 64'h1);
        chk("R8", "counts before match", 64'(cnt_hi2lo + cnt_lo2hi), 0);
        for (int i = 5; i <= 8; i++) begin
            gen(0, w); step(w, 1'b1);
        end
        chk("R4", "run restarted, not yet matched", 64'(matched), 0);
        gen(0, w); step(w, 1'b1);
        chk("R4", "matched after run", 64'(matched), 1);

        // R5 R8 table walk after match
        for (int i = 0; i < 8; i++) begin
            gen(0, w);
            step(w ^ FLIPS[i], 1'b1);
            tally(w, FLIPS[i]);
            chk("R5", "table mask", 64'(err_mask), 64'(FLIPS[i]));
            chk_cnts("R8");
        end

        // R6 burst of fully inverted words
        for (int i = 0; i < 3; i++) begin
            gen(0, w);
            step(~w, 1'b1);
            tally(w, '1);
            chk("R6", "matched through burst", 64'(matched), 1);
        end
        chk_cnts("R8");
        gen(0, w); step(w, 1'b1);
        chk("R5", "clean after burst", 64'(err_mask), 0);

        // R7 loss of link
        link_ok = 1'b0;
        gen(0, w); step(~w, 1'b1);
        chk("R7", "matched cleared", 64'(matched), 0);
        chk("R7", "no mask while down", 64'(err_mask_vld), 0);
        chk_cnts("R8");
        link_ok = 1'b1;
        gen(0, w); step(~w, 1'b1);
        chk("R7", "reseed word not compared", 64'(err_mask_vld), 0);
        gen(0, w); step(~w ^ 32'h0000_0100, 1'b1);
        chk("R8", "errored while unmatched", 64'(err_mask_vld), 1);
        chk_cnts("R8");

        // R1 R4 x^31+x^28+1 with run of 0
        pat_sel   = 2'd3;
        match_run = 8'd0;
        gen(3, w); step(w, 1'b1);
        gen(3, w); step(w, 1'b1);
        chk("R4", "run 0 acts as 1", 64'(matched), 1);
        gen(3, w); step(w ^ 32'h0000_0020, 1'b1);
        tally(w, 32'h0000_0020);
        chk("R1", "order-31 mask", 64'(err_mask), 64'h20);
        chk_cnts("R8");

        // idle cycles change nothing
        step('0, 1'b0);
        chk("R3", "no mask when idle", 64'(err_mask_vld), 0);
        chk_cnts("R8");

        // R9 saturation
        for (int i = 0; i < 40; i++) begin
            gen(3, w);
            step(~w, 1'b1);
            tally(w, '1);
        end
        chk("R9", "hi2lo saturated", 64'(cnt_hi2lo), 64'(CMAX));
        chk("R9", "lo2hi saturated", 64'(cnt_lo2hi), 64'(CMAX));
        chk("R6", "still matched", 64'(matched), 1);
        gen(3, w); step(w, 1'b1);
        chk("R5", "clean after long burst", 64'(err_mask), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule